// File: doc/BRIEF.md
# Warp Memory Request Line Coalescer

This block takes one memory request issued by a whole warp and turns it into the smallest set of cache-line transactions. The request holds one byte address per lane, a mask of the lanes that take part, and an access size code. The block groups the active lanes by the aligned line each lane touches. It then sends one line transaction per cycle over a valid/ready handshake. Each transaction carries the line's base address and a mask of every lane that the line serves.

Before any transaction goes out, the block checks that every active lane is aligned to the access size. If any active lane fails, or the size code is the unsupported oversized one, the request produces a done pulse with an error flag and no transactions. When the request finishes, a one-cycle done pulse reports how many line transactions it produced. The block takes a new request only when it is idle. The lane count, address width and line size are parameters. The defaults are 32 lanes, 32-bit addresses and 128-byte lines.

Top module: `warp_line_coalescer`

## Requirements
- R1: The address of each transaction is the lead lane's byte address with its low log2(LINE_BYTES) bits cleared. Its lane mask (bit i = lane i) has a bit set for every still-unserved active lane whose address lies in that line.
- R2: Transactions go out in order of the lowest-numbered active lane that no earlier transaction has served.
- R3: If LANES × 4 equals LINE_BYTES and the lanes access contiguous 4-byte words starting on a line boundary, exactly one transaction goes out, with every active lane in its mask.
- R4: The same contiguous pattern moved off the line boundary produces two transactions. In general the number of transactions equals the number of distinct lines that the active lanes touch.
- R5: Size codes are 0 = 4 bytes, 1 = 8 bytes and 2 = 16 bytes. An active lane whose address is not a multiple of its size makes the request end with done_err high, done_count 0 and no transaction.
- R6: Size code 3 (32 bytes, which is oversized) is an error whenever at least one lane is active. It gives the same outcome as R5.
- R7: Inactive lanes have no effect. Their addresses are neither grouped nor checked for alignment.
- R8: A request with an all-zero lane mask ends with done high, done_err low, done_count 0 and no transaction.
- R9: req_ready is high only while the block is idle. It goes low in the cycle after a request is accepted and comes back in the cycle after the done pulse.
- R10: While txn_valid is high and txn_ready is low, txn_valid, txn_line and txn_lanes hold their values.
- R11: done is a one-cycle pulse. For a request that issues transactions, it comes in the cycle after the last transaction is accepted, and done_count gives the number of transactions (0 to LANES).
- R12: After reset, req_ready is high and txn_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | LANES*AW | Lane byte addresses, lane i in bits [i*AW +: AW] |
| req_mask | input | LANES | Active-lane mask |
| req_size | input | 2 | Access size code (0: 4 B, 1: 8 B, 2: 16 B, 3: 32 B, which is illegal) |
| txn_valid | output | 1 | Line transaction present |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_line | output | AW | Line base byte address |
| txn_lanes | output | LANES | Lanes served by this line |
| done | output | 1 | Request finished (one cycle) |
| done_err | output | 1 | Alignment or size error, valid with done |
| done_count | output | $clog2(LANES+1) | Transactions issued, valid with done |

## Verification
The bench builds the block with 8 lanes, 12-bit addresses and 32-byte lines. With these values 8 lanes of 4 bytes fill exactly one line, so the one-line and two-line cases of R3 and R4 arise exactly as they do at the default sizes. With 8 lanes and 12-bit addresses, a full sweep of strides and offsets is small, and so is a long pseudo-random run, and each case can be compared against a line-grouping model computed in the bench. Random backpressure on txn_ready exercises the hold behaviour, and each lane in turn is made misaligned, inactive, or mapped to its own line.

// File: rtl/wcoal_pkg.sv
package wcoal_pkg;

   typedef enum logic [1:0] {
      SZ_B4  = 2'd0,
      SZ_B8  = 2'd1,
      SZ_B16 = 2'd2,
      SZ_B32 = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_ISSUE = 2'd2,
      ST_DONE  = 2'd3
   } co_state_e;

   // Number of low address bits that must be zero for a given size code.
   function automatic int unsigned align_bits(acc_size_e sz);
      case (sz)
         SZ_B4:   return 2;
         SZ_B8:   return 3;
         SZ_B16:  return 4;
         default: return 5;
      endcase
   endfunction

endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
   import wcoal_pkg::*;
#(
   parameter int LANES = 32
) (
   input  logic [LANES*4-1:0] lane_low,
   input  logic [LANES-1:0]   lane_mask,
   input  acc_size_e          acc_size,
   output logic               any_bad
);

   logic [LANES-1:0] lane_bad;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [3:0] low;
      logic       misal;
      assign low = lane_low[i*4 +: 4];
      always_comb begin
         case (acc_size)
            SZ_B4:   misal = |low[1:0];
            SZ_B8:   misal = |low[2:0];
            SZ_B16:  misal = |low[3:0];
            default: misal = 1'b1;
         endcase
      end
      assign lane_bad[i] = lane_mask[i] & misal;
   end

   assign any_bad = |lane_bad;

endmodule

// File: rtl/lane_first_pick.sv
module lane_first_pick #(
   parameter int LANES       = 32,
   parameter bit ONEHOT_PICK = 1'b1,
   localparam int IW         = $clog2(LANES)
) (
   input  logic [LANES-1:0] pend,
   output logic [IW-1:0]    lead,
   output logic             found
);

   assign found = |pend;

   if (ONEHOT_PICK) begin : g_onehot
      logic [LANES-1:0] iso;
      assign iso = pend & (~pend + LANES'(1));
      always_comb begin
         lead = '0;
         for (int i = 0; i < LANES; i++) begin
            if (iso[i]) lead = lead | IW'(i);
         end
      end
   end else begin : g_scan
      always_comb begin
         lead = '0;
         for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) lead = IW'(i);
         end
      end
   end

endmodule

// File: rtl/line_match.sv
module line_match #(
   parameter int LANES = 32,
   parameter int TW    = 25,
   localparam int IW   = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES*TW-1:0] lane_tag,
   input  logic [LANES-1:0]  pend,
   input  logic [IW-1:0]     lead,
   output logic [TW-1:0]     lead_tag,
   output logic [LANES-1:0]  hit
);

   logic [TW-1:0] tag_a [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_unpack
      assign tag_a[i] = lane_tag[i*TW +: TW];
   end

   assign lead_tag = tag_a[lead];

   for (genvar i = 0; i < LANES; i++) begin : g_cmp
      assign hit[i] = pend[i] && (tag_a[i] == lead_tag);
   end

   // R1: the lead lane always belongs to its own line group
   a_r1_lead_in_group: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend) |-> hit[lead]);

endmodule

// File: rtl/warp_line_coalescer.sv
module warp_line_coalescer
   import wcoal_pkg::*;
#(
   parameter int LANES       = 32,
   parameter int AW          = 32,
   parameter int LINE_BYTES  = 128,
   parameter bit ONEHOT_PICK = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [LANES*AW-1:0]          req_addr,
   input  logic [LANES-1:0]             req_mask,
   input  logic [1:0]                   req_size,
   output logic                         txn_valid,
   input  logic                         txn_ready,
   output logic [AW-1:0]                txn_line,
   output logic [LANES-1:0]             txn_lanes,
   output logic                         done,
   output logic                         done_err,
   output logic [$clog2(LANES+1)-1:0]   done_count
);

   localparam int IW  = $clog2(LANES);
   localparam int CW  = $clog2(LANES + 1);
   localparam int LBB = $clog2(LINE_BYTES);
   localparam int TW  = AW - LBB;

   if (LANES < 2) begin : g_bad_lanes
      $error("LANES must be at least 2");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 16) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 16");
   end
   if (AW <= LBB) begin : g_bad_aw
      $error("AW must exceed the line offset width");
   end

   co_state_e         st_q;
   logic [LANES*AW-1:0] addr_q;
   logic [LANES-1:0]  pend_q;
   acc_size_e         size_q;
   logic [CW-1:0]     cnt_q;
   logic              err_q;

   logic [LANES*4-1:0]  lane_low;
   logic [LANES*TW-1:0] lane_tag;
   logic              bad;
   logic [IW-1:0]     lead;
   logic              found;
   logic [TW-1:0]     lead_tag;
   logic [LANES-1:0]  hit;
   logic [LANES-1:0]  rest;
   logic              fire;

   for (genvar i = 0; i < LANES; i++) begin : g_split
      assign lane_low[i*4 +: 4]   = addr_q[i*AW +: 4];
      assign lane_tag[i*TW +: TW] = addr_q[i*AW + LBB +: TW];
      if (LBB > 4) begin : g_mid
         logic [LBB-5:0] mid_unused;
         assign mid_unused = addr_q[i*AW + 4 +: LBB - 4];
      end
   end

   lane_align_check #(.LANES(LANES)) u_align (
      .lane_low  (lane_low),
      .lane_mask (pend_q),
      .acc_size  (size_q),
      .any_bad   (bad)
   );

   lane_first_pick #(.LANES(LANES), .ONEHOT_PICK(ONEHOT_PICK)) u_pick (
      .pend  (pend_q),
      .lead  (lead),
      .found (found)
   );

   line_match #(.LANES(LANES), .TW(TW)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_tag (lane_tag),
      .pend     (pend_q),
      .lead     (lead),
      .lead_tag (lead_tag),
      .hit      (hit)
   );

   assign fire = txn_valid & txn_ready;
   assign rest = pend_q & ~hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         pend_q <= '0;
         size_q <= SZ_B4;
         cnt_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q <= req_addr;
                  pend_q <= req_mask;
                  size_q <= acc_size_e'(req_size);
                  cnt_q  <= '0;
                  err_q  <= 1'b0;
                  st_q   <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (bad) begin
                  err_q  <= 1'b1;
                  pend_q <= '0;
                  st_q   <= ST_DONE;
               end else if (!found) begin
                  st_q <= ST_DONE;
               end else begin
                  st_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (fire) begin
                  pend_q <= rest;
                  cnt_q  <= cnt_q + CW'(1);
                  if (rest == '0) st_q <= ST_DONE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (st_q == ST_IDLE);
   assign txn_valid  = (st_q == ST_ISSUE);
   assign txn_line   = {lead_tag, {LBB{1'b0}}};
   assign txn_lanes  = hit;
   assign done       = (st_q == ST_DONE);
   assign done_err   = done & err_q;
   assign done_count = done ? cnt_q : '0;

   // R10: held under backpressure
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && !txn_ready |=> txn_valid && $stable(txn_line) && $stable(txn_lanes));

   // R9: no acceptance while transactions are outstanding
   a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> !req_ready);

   // R11: done lasts one cycle and is followed by idle
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && req_ready);

   // R5: an error report carries a zero count
   a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done && done_err |-> done_count == '0);

   // R1: every transaction serves at least one lane
   a_r1_lanes_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> (|txn_lanes));

   // R4: count never exceeds the lane count
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> int'(done_count) <= LANES);

   // R11: done and a transaction never coexist
   a_r11_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !txn_valid);

endmodule

// File: tb/test_warp_line_coalescer.sv
module test_warp_line_coalescer;

   localparam int N  = 8;
   localparam int AW = 12;
   localparam int LB = 32;
   localparam int CW = $clog2(N + 1);

   typedef logic [AW-1:0] addr_arr_t [N];

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [N*AW-1:0] req_addr = '0;
   logic [N-1:0] req_mask = '0;
   logic [1:0] req_size = '0;
   logic txn_valid;
   logic txn_ready = 1'b0;
   logic [AW-1:0] txn_line;
   logic [N-1:0] txn_lanes;
   logic done, done_err;
   logic [CW-1:0] done_count;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] rng = 16'hACE1;

   always #2.5 clk = ~clk;

   warp_line_coalescer #(.LANES(N), .AW(AW), .LINE_BYTES(LB)) i_warp_line_coalescer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_mask(req_mask), .req_size(req_size),
      .txn_valid(txn_valid), .txn_ready(txn_ready),
      .txn_line(txn_line), .txn_lanes(txn_lanes),
      .done(done), .done_err(done_err), .done_count(done_count)
   );

   function automatic logic [15:0] step(logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run(input addr_arr_t av, input logic [N-1:0] m,
                      input logic [1:0] sz, input bit bp, input string req);
      logic [AW-1:0] e_line [N];
      logic [N-1:0]  e_mask [N];
      int e_n = 0;
      bit e_err = 1'b0;
      logic [N-1:0] pend = m;
      int got = 0;
      bit seen_done = 1'b0;
      int bytes = 4 << sz;
      // expected grouping
      if (m != 0 && sz == 2'd3) e_err = 1'b1;
      for (int i = 0; i < N; i++)
         if (m[i] && (int'(av[i]) % bytes) != 0) e_err = 1'b1;
      while (!e_err && pend != 0) begin
         int lead = 0;
         logic [AW-1:0] ln;
         for (int i = N - 1; i >= 0; i--) if (pend[i]) lead = i;
         ln = av[lead] & ~AW'(LB - 1);
         e_line[e_n] = ln;
         e_mask[e_n] = '0;
         for (int i = 0; i < N; i++)
            if (pend[i] && ((av[i] & ~AW'(LB - 1)) == ln)) e_mask[e_n][i] = 1'b1;
         pend = pend & ~e_mask[e_n];
         e_n++;
      end
      // drive the request
      chk(req_ready == 1'b1, "R9", "ready when idle", int'(req_ready), 1);
      for (int i = 0; i < N; i++) req_addr[i*AW +: AW] = av[i];
      req_mask = m;
      req_size = sz;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R9", "ready low after accept", int'(req_ready), 0);
      for (int cyc = 0; cyc < 400 && !seen_done; cyc++) begin
         rng = step(rng);
         txn_ready = bp ? rng[0] : 1'b1;
         #1;
         if (txn_valid && txn_ready) begin
            if (got < e_n) begin
               chk(txn_line == e_line[got], req, "line address", int'(txn_line), int'(e_line[got]));
               chk(txn_lanes == e_mask[got], req, "lane mask", int'(txn_lanes), int'(e_mask[got]));
            end
            got++;
         end
         if (done) begin
            seen_done = 1'b1;
            chk(got == e_n, req, "transactions seen", got, e_n);
            chk(int'(done_count) == e_n, req, "done count", int'(done_count), e_n);
            chk(done_err == e_err, req, "error flag", int'(done_err), int'(e_err));
         end
         @(negedge clk);
      end
      chk(seen_done, "R11", "done reached", int'(seen_done), 1);
      txn_ready = 1'b0;
      #1;
      chk(done == 1'b0, "R11", "done single cycle", int'(done), 0);
      chk(req_ready == 1'b1, "R9", "ready after done", int'(req_ready), 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      addr_arr_t a;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(req_ready == 1'b1, "R12", "ready in reset", int'(req_ready), 1);
      chk(txn_valid == 1'b0, "R12", "txn_valid in reset", int'(txn_valid), 0);
      chk(done == 1'b0, "R12", "done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 contiguous aligned words: one line
      for (int i = 0; i < N; i++) a[i] = AW'(64 + 4 * i);
      run(a, 8'hFF, 2'd0, 1'b0, "R3");
      // R4 shifted by one word: two lines
      for (int i = 0; i < N; i++) a[i] = AW'(68 + 4 * i);
      run(a, 8'hFF, 2'd0, 1'b1, "R4");
      // R4 every lane its own line
      for (int i = 0; i < N; i++) a[i] = AW'(LB * i + 8);
      run(a, 8'hFF, 2'd0, 1'b1, "R4");
      // R2 reversed line order, lane 0 first
      for (int i = 0; i < N; i++) a[i] = AW'(LB * (N - 1 - i));
      run(a, 8'hFF, 2'd0, 1'b1, "R2");
      // R2 interleaved lines
      for (int i = 0; i < N; i++) a[i] = AW'(((i % 3) * LB * 5) + 4 * i);
      run(a, 8'hFF, 2'd0, 1'b1, "R2");
      // R1 broadcast of one address
      for (int i = 0; i < N; i++) a[i] = AW'(12'h3A4);
      run(a, 8'hFF, 2'd0, 1'b0, "R1");
      // 8-byte and 16-byte contiguous
      for (int i = 0; i < N; i++) a[i] = AW'(256 + 8 * i);
      run(a, 8'hFF, 2'd1, 1'b1, "R4");
      for (int i = 0; i < N; i++) a[i] = AW'(512 + 16 * i);
      run(a, 8'hFF, 2'd2, 1'b1, "R4");
      // R5 one lane misaligned for its size, each lane in turn
      for (int k = 0; k < N; k++) begin
         for (int i = 0; i < N; i++) a[i] = AW'(16 * i);
         a[k] = a[k] + AW'(8);
         run(a, 8'hFF, 2'd2, 1'b0, "R5");
      end
      for (int i = 0; i < N; i++) a[i] = AW'(8 * i);
      a[3] = AW'(28);
      run(a, 8'hFF, 2'd1, 1'b0, "R5");
      // R7 misaligned lane masked off
      run(a, 8'hF7, 2'd1, 1'b1, "R7");
      // R7 inactive lanes far away do not add lines
      for (int i = 0; i < N; i++) a[i] = (i < 4) ? AW'(4 * i) : AW'(1024 + LB * i);
      run(a, 8'h0F, 2'd0, 1'b0, "R7");
      // R6 oversized size code
      for (int i = 0; i < N; i++) a[i] = AW'(32 * i);
      run(a, 8'h01, 2'd3, 1'b0, "R6");
      // R8 empty mask, also with the oversized code
      run(a, 8'h00, 2'd0, 1'b0, "R8");
      run(a, 8'h00, 2'd3, 1'b0, "R8");

      // R4 sweep of strides and offsets
      for (int s = 0; s < 10; s++) begin
         for (int off = 0; off < LB; off += 4) begin
            for (int i = 0; i < N; i++) a[i] = AW'(off + 128 + 4 * s * i);
            run(a, 8'hFF, 2'd0, bit'(s % 2), "R4");
         end
      end
      // R1 pseudo-random addresses and masks
      for (int t = 0; t < 60; t++) begin
         logic [N-1:0] m;
         for (int i = 0; i < N; i++) begin
            rng = step(rng);
            a[i] = {rng[11:6] & 6'h07, rng[5:2], 2'b00};
         end
         rng = step(rng);
         m = rng[N-1:0];
         run(a, m, 2'd0, 1'b1, "R1");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule